// File: doc/BRIEF.md
# Variable-Length Delay Line Address Generator

This block steps through a circular buffer of sample slots in RAM so that a stream of samples comes back out a fixed number of sample periods after it went in. An external clock of variable rate supplies a one-cycle strobe for each sample. On each strobe the block starts a short sequence. First it marks a read of the oldest sample at the current slot. Next it marks a write of the new sample into that same slot. Finally it moves on to the next slot.

The number of slots in the loop is set by a 10-bit delay word, scaled up by 64. The largest setting therefore covers almost the whole 16-bit address space. The delay in time is the loop length multiplied by the sample period. Changing the rate of the sample strobe moves the delay by small amounts, which suits modulation. Changing the delay word moves it in large steps. A new delay word takes effect only when the address wraps back to zero, so the loop never jumps to a slot past its new end. A single-bit write-gate input can block the write strobe without changing the sequence.

Top module: `delayAddrGen`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `memAddr` is 0 and both `rdPhase` and `wrPhase` are 0. Reset loads the loop length from `delaySet`.
- R2: When `sampleStb` is seen high on a clock edge while the block is idle, `rdPhase` is 1 for exactly the next cycle, and `memAddr` still holds the current slot.
- R3: In the cycle after the read phase, `wrPhase` equals `wrGate` and `memAddr` holds the same slot. `wrPhase` is never 1 outside that cycle.
- R4: At the edge that ends the write phase, the address advances by one. At no other time does it change, except on reset or at a wrap.
- R5: The loop length in slots is `delaySet` multiplied by 64. A setting of 0 is treated as 1, which gives 64 slots.
- R6: When the slot that ends the write phase is the last one (length minus 1), the address wraps to 0. The address always stays below the loop length.
- R7: A new `delaySet` value is sampled only at a wrap. Changing the setting mid-loop has no effect on the current loop.
- R8: A strobe that arrives while a read or write phase is in progress is ignored. Such a strobe adds no extra read phase and no extra address step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleStb | input | 1 | One-cycle strobe per sample from the variable-rate clock |
| delaySet | input | 10 | Coarse delay setting; loop length = setting × 64 |
| wrGate | input | 1 | Enables the write strobe during the write phase |
| memAddr | output | 16 | Current buffer slot address |
| rdPhase | output | 1 | High for the read cycle of a sample period |
| wrPhase | output | 1 | High for the write cycle when `wrGate` is high |

## Verification
On every cycle, assertions check the following: the read and write phases never overlap, and a write always follows a read. The write strobe respects the gate. The address changes only on an advance and then only by one step or a wrap. It stays inside the loop, and the latched length changes only at a wrap. Some behaviour shows only in the bench's scenarios, which compare the output against a reference model: the exact loop lengths that each setting produces, the setting of 0 being treated as 64 slots, a setting changed mid-loop being held off until the wrap, and extra strobes during a busy period being ignored.

// File: rtl/delayAddrPkg.sv
package delayAddrPkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seqState_t;

  typedef struct packed {
    logic doRead;
    logic doWrite;
    logic doAdvance;
  } seqStrobes_t;
endpackage

// File: rtl/delayAddrCtrl.sv
module delayAddrCtrl
  import delayAddrPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sampleStb,
  output seqStrobes_t strb
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      SEQ_IDLE:  if (sampleStb) stateNext = SEQ_READ;
      SEQ_READ:  stateNext = SEQ_WRITE;
      SEQ_WRITE: stateNext = SEQ_IDLE;
      default:   stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SEQ_IDLE;
    else     state <= stateNext;
  end

  // advance happens on the edge that closes the write cycle
  always_comb begin
    strb.doRead    = (state == SEQ_READ);
    strb.doWrite   = (state == SEQ_WRITE);
    strb.doAdvance = (state == SEQ_WRITE);
  end

  // R8: read and write cycles never overlap
  a_r8_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.doRead, strb.doWrite}));

  // R3: a write cycle is always preceded by a read cycle
  a_r3_write_after_read: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_WRITE) |-> $past(state == SEQ_READ));

  // R2: an idle strobe starts a read on the next cycle
  a_r2_strobe_starts_read: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_IDLE && sampleStb) |=> (state == SEQ_READ));
endmodule

// File: rtl/delayAddrPath.sv
module delayAddrPath
  import delayAddrPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SET_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strb,
  input  logic [SET_W-1:0]  delaySet,
  input  logic              wrGate,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rdPhase,
  output logic              wrPhase
);
  localparam int SCALE_SH = ADDR_W - SET_W;

  logic [SET_W-1:0]  setClamped;
  logic [ADDR_W-1:0] newLen;
  logic [ADDR_W-1:0] activeLen;
  logic [ADDR_W-1:0] lastAddr;
  logic [ADDR_W-1:0] addrQ;
  logic              atWrap;

  assign setClamped = (delaySet == '0) ? SET_W'(1) : delaySet;

  generate
    if (SCALE_SH > 0) begin : g_scaled
      assign newLen = {setClamped, {SCALE_SH{1'b0}}};
    end else begin : g_direct
      assign newLen = setClamped[ADDR_W-1:0];
    end
  endgenerate

  assign lastAddr = activeLen - ADDR_W'(1);
  assign atWrap   = (addrQ >= lastAddr);

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ     <= '0;
      activeLen <= newLen;
    end else if (strb.doAdvance) begin
      if (atWrap) begin
        addrQ     <= '0;
        activeLen <= newLen;
      end else begin
        addrQ <= addrQ + ADDR_W'(1);
      end
    end
  end

  assign memAddr = addrQ;
  assign rdPhase = strb.doRead;
  assign wrPhase = strb.doWrite & wrGate;

  // R6: the address never leaves the active loop
  a_r6_addr_in_loop: assert property (@(posedge clk) disable iff (rst)
    addrQ < activeLen);

  // R4: without an advance the address holds
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !strb.doAdvance |=> $stable(addrQ));

  // R4, R6: an advance steps by one or wraps to zero
  a_r4_step_or_wrap: assert property (@(posedge clk) disable iff (rst)
    strb.doAdvance |=> (addrQ == $past(addrQ) + ADDR_W'(1) || addrQ == '0));

  // R7: the loop length changes only at a wrap
  a_r7_len_only_at_wrap: assert property (@(posedge clk) disable iff (rst)
    !(strb.doAdvance && atWrap) |=> $stable(activeLen));

  // R3: the write strobe obeys the gate
  a_r3_write_gated: assert property (@(posedge clk) disable iff (rst)
    wrPhase |-> (wrGate && strb.doWrite));
endmodule

// File: rtl/delayAddrGen.sv
module delayAddrGen
  import delayAddrPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SET_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleStb,
  input  logic [SET_W-1:0]  delaySet,
  input  logic              wrGate,
  output logic [ADDR_W-1:0] memAddr,
  output logic              rdPhase,
  output logic              wrPhase
);
  seqStrobes_t strb;

  delayAddrCtrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .sampleStb (sampleStb),
    .strb      (strb)
  );

  delayAddrPath #(
    .ADDR_W (ADDR_W),
    .SET_W  (SET_W)
  ) path_i (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .delaySet (delaySet),
    .wrGate   (wrGate),
    .memAddr  (memAddr),
    .rdPhase  (rdPhase),
    .wrPhase  (wrPhase)
  );
endmodule

// File: tb/delayAddrGen_tb_top.sv
module delayAddrGen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sampleStb = 1'b0;
  logic [9:0]  delaySet = 10'd1;
  logic        wrGate = 1'b0;
  logic [15:0] memAddr;
  logic        rdPhase;
  logic        wrPhase;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int expAddr;
  int expLen;

  always #10 clk = ~clk;

  delayAddrGen dut_i (
    .clk(clk), .rst(rst), .sampleStb(sampleStb), .delaySet(delaySet),
    .wrGate(wrGate), .memAddr(memAddr), .rdPhase(rdPhase), .wrPhase(wrPhase)
  );

  function automatic int lenOf(input int s);
    return ((s == 0) ? 1 : s) * 64;
  endfunction

  function automatic int nextAddr(input int a, input int len);
    return (a == len - 1) ? 0 : a + 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one sample period; extra=1 keeps the strobe high into the read cycle (R8)
  task automatic doSample(input bit gate, input bit extra, input bit full);
    @(negedge clk);
    sampleStb = 1'b1;
    wrGate = gate;
    @(negedge clk);
    sampleStb = extra;
    if (full) begin
      chk("R2 rdPhase", rdPhase, 1);
      chk("R2 addr in read", memAddr, expAddr);
    end
    @(negedge clk);
    sampleStb = 1'b0;
    if (full) begin
      chk("R3 wrPhase", wrPhase, gate);
      chk("R3 rd low in write", rdPhase, 0);
      chk("R3 addr in write", memAddr, expAddr);
    end
    if (expAddr == expLen - 1) begin
      expAddr = 0;
      expLen = lenOf(delaySet);
    end else begin
      expAddr = expAddr + 1;
    end
    @(negedge clk);
    if (full) begin
      chk("R4 addr advanced", memAddr, expAddr);
      chk("R8 no extra read", rdPhase, 0);
      chk("R3 wr low after", wrPhase, 0);
    end
  endtask

  task automatic doReset(input int s);
    @(negedge clk);
    rst = 1'b1;
    delaySet = 10'(s);
    @(negedge clk);
    chk("R1 addr in reset", memAddr, 0);
    chk("R1 rd in reset", rdPhase, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 addr after reset", memAddr, 0);
    chk("R1 wr after reset", wrPhase, 0);
    expAddr = 0;
    expLen = lenOf(s);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    // R1 reset state
    doReset(1);

    // R5 R6: setting 1 gives 64 slots, then wraps
    for (int i = 0; i < 63; i++) doSample(1'b1, 1'b0, 1'b1);
    chk("R5 last slot of 64", memAddr, 63);
    doSample(1'b1, 1'b0, 1'b1);
    chk("R6 wrap to zero", memAddr, 0);

    // R5: setting 0 behaves as 64 slots
    doReset(0);
    for (int i = 0; i < 64; i++) doSample(1'b0, 1'b0, 1'b0);
    chk("R5 zero setting wraps at 64", memAddr, 0);

    // R7: change mid-loop is held until the wrap
    doReset(2);
    for (int i = 0; i < 10; i++) doSample(1'b1, 1'b0, 1'b0);
    delaySet = 10'd1;
    for (int i = 0; i < 118; i++) doSample(1'b1, 1'b0, 1'b0);
    chk("R7 old length kept", memAddr, 0);
    for (int i = 0; i < 64; i++) doSample(1'b1, 1'b0, 1'b0);
    chk("R7 new length after wrap", memAddr, 0);

    // R5: full-scale setting does not wrap early
    doReset(1023);
    for (int i = 0; i < 70; i++) doSample(1'b0, 1'b0, 1'b0);
    chk("R5 large loop no early wrap", memAddr, 70);

    // R8: extra strobe during busy period ignored
    doSample(1'b1, 1'b1, 1'b1);
    chk("R8 single step", memAddr, 71);

    // R4: address holds while idle with no strobe
    repeat (5) @(negedge clk);
    chk("R4 hold idle", memAddr, 71);

    // random mix
    doReset(2);
    for (int i = 0; i < 2000; i++) begin
      if ($urandom % 50 == 0) delaySet = 10'($urandom % 4);
      doSample(1'($urandom % 2), 1'($urandom % 4 == 0), 1'b1);
      repeat ($urandom % 3) @(negedge clk);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule